// File: doc/BRIEF.md
# Reset Sequencer with Vector Selection

This block produces the internal reset of a microcontroller core. Reset requests arrive from a power-on input, a low-voltage detector, an illegal-address detector, a watchdog timeout, a clock-loss monitor and an open-drain reset pad. When any of them fires, the block pulls the pad low and starts counting system clock cycles. After a fixed drive interval it lets go of the pad and waits out a release window. At the end of that window it samples the pad. Internal reset is then removed on a clock edge.

The sampled pad level, together with the latched watchdog and clock-loss flags, picks the reset vector. A pad that is still low shows that an outside agent is holding reset, so the general vector is chosen. Otherwise the clock-loss flag takes priority over the watchdog flag. The chosen code is held from the end of reset until the next reset event.

The pad input goes through a two-stage synchronizer. The pad output is modelled as an active-high drive-low enable. The power-on input `porN` is an active-low asynchronous reset, and it also counts as a reset source.

Top module: `reset_sequencer`

## Requirements
- R1: After a reset event, `coreRst` stays high for DRIVE_CYC + RELEASE_CYC cycles. With the defaults this is 131 + 64 = 195 cycles, counted from the first clock edge that sees the request, or from the release of `porN`. It then falls on a clock edge.
- R2: `padDriveLow` is high for the first DRIVE_CYC = 128 + SYNC_N cycles of a sequence (131 with SYNC_N = 3) and is low otherwise.
- R3: The pad input passes through a two-flop synchronizer. A pad held low from outside while the block is idle starts a sequence: `coreRst` is high after the third rising edge following the pad going low, and is still low after the second.
- R4: If the synchronized pad is low at the end of the release window, `coreRst` stays high until the pad returns high. It falls after the third edge following the pad release.
- R5: `vecSel` uses these codes: 2'b00 for power-on, low-voltage, illegal-address or external reset; 2'b01 for clock loss; 2'b10 for watchdog. A pad sampled low selects 2'b00 whatever flags are pending.
- R6: A pad sampled high with the clock-loss flag pending selects 2'b01, whether or not the watchdog flag is also pending.
- R7: A pad sampled high with only the watchdog flag pending selects 2'b10. With no flag pending it selects 2'b00.
- R8: The watchdog and clock-loss flags are set by their requests and cleared when `coreRst` falls. A later sequence caused by another source therefore selects 2'b00.
- R9: Any request that arrives while `coreRst` is high restarts the sequence from its first drive cycle.
- R10: `vecSel` keeps its value while `coreRst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| lowVoltReq | input | 1 | Low-voltage reset request |
| illegalAddrReq | input | 1 | Illegal-address reset request |
| copReq | input | 1 | Watchdog timeout reset request |
| clkMonReq | input | 1 | Clock-loss reset request |
| padIn | input | 1 | Level seen on the reset pad |
| padDriveLow | output | 1 | Enable that pulls the reset pad low |
| coreRst | output | 1 | Internal reset, active high |
| vecSel | output | 2 | Reset vector selection code |

## Verification
The hardest case to reach is an outside agent holding the pad low across the whole release window while a watchdog flag is pending. This is the only way to exercise the hold-until-high path and the rule that a low pad overrides the flags. The bench models the open-drain pad as the AND of the block's drive and an external pull-down. It holds the pull-down for several hundred cycles, pulses a watchdog request inside that span, and then releases the pad. It then checks the exact edge at which reset falls. Restart is reached by placing a second request a fixed number of cycles into a running sequence and checking the lengthened reset interval.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2,
    ST_HOLD    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic latchFromFlags;
    logic latchGeneral;
    logic clrFlags;
  } seqStrobe_t;

  localparam logic [1:0] VEC_GENERAL = 2'b00;
  localparam logic [1:0] VEC_CLKMON  = 2'b01;
  localparam logic [1:0] VEC_COP     = 2'b10;

endpackage

// File: rtl/rseq_path.sv
module rseq_path
  import rseq_pkg::*;
#(
  parameter int DRIVE_CYC   = 131,
  parameter int RELEASE_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  seqStrobe_t strobe,
  input  logic       copReq,
  input  logic       clkMonReq,
  input  logic       padIn,
  output logic       padSync,
  output logic       driveDone,
  output logic       releaseDone,
  output logic       copPend,
  output logic       clkMonPend,
  output logic [1:0] vecSel
);

  localparam int LONGEST = (DRIVE_CYC > RELEASE_CYC) ? DRIVE_CYC : RELEASE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST   = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] RELEASE_LAST = CNT_W'(RELEASE_CYC - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       cycCnt;

  // pad synchronizer, resets to the released (high) level
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          syncChain[g] <= 1'b1;
        end else if (g == 0) begin
          syncChain[g] <= padIn;
        end else begin
          syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign padSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cycCnt <= '0;
    end else if (strobe.cntClr) begin
      cycCnt <= '0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assign driveDone   = (cycCnt == DRIVE_LAST);
  assign releaseDone = (cycCnt == RELEASE_LAST);

  // a new request wins over the clear issued at the end of reset
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      copPend    <= 1'b0;
      clkMonPend <= 1'b0;
    end else begin
      if (copReq) begin
        copPend <= 1'b1;
      end else if (strobe.clrFlags) begin
        copPend <= 1'b0;
      end
      if (clkMonReq) begin
        clkMonPend <= 1'b1;
      end else if (strobe.clrFlags) begin
        clkMonPend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      vecSel <= VEC_GENERAL;
    end else if (strobe.latchGeneral) begin
      vecSel <= VEC_GENERAL;
    end else if (strobe.latchFromFlags) begin
      if (clkMonPend) begin
        vecSel <= VEC_CLKMON;
      end else if (copPend) begin
        vecSel <= VEC_COP;
      end else begin
        vecSel <= VEC_GENERAL;
      end
    end
  end

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       anyReq,
  input  logic       padSync,
  input  logic       driveDone,
  input  logic       releaseDone,
  output seqStrobe_t strobe,
  output logic       padDriveLow,
  output logic       coreRst
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= ST_DRIVE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.cntClr = 1'b1;
        if (anyReq || !padSync) begin
          stateNext = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (anyReq) begin
          strobe.cntClr = 1'b1;
        end else if (driveDone) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (anyReq) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_DRIVE;
        end else if (releaseDone) begin
          strobe.cntClr = 1'b1;
          if (padSync) begin
            strobe.latchFromFlags = 1'b1;
            strobe.clrFlags       = 1'b1;
            stateNext             = ST_IDLE;
          end else begin
            stateNext = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        strobe.cntClr = 1'b1;
        if (anyReq) begin
          stateNext = ST_DRIVE;
        end else if (padSync) begin
          strobe.latchGeneral = 1'b1;
          strobe.clrFlags     = 1'b1;
          stateNext           = ST_IDLE;
        end
      end
      default: stateNext = ST_DRIVE;
    endcase
  end

  assign padDriveLow = (state == ST_DRIVE);
  assign coreRst     = (state != ST_IDLE);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rseq_pkg::*;
#(
  parameter int SYNC_N      = 3,
  parameter int BASE_DRIVE  = 128,
  parameter int RELEASE_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       lowVoltReq,
  input  logic       illegalAddrReq,
  input  logic       copReq,
  input  logic       clkMonReq,
  input  logic       padIn,
  output logic       padDriveLow,
  output logic       coreRst,
  output logic [1:0] vecSel
);

  localparam int DRIVE_CYC = BASE_DRIVE + SYNC_N;

  seqStrobe_t strobe;
  logic padSync, driveDone, releaseDone, copPend, clkMonPend, anyReq;

  assign anyReq = lowVoltReq | illegalAddrReq | copReq | clkMonReq;

  rseq_ctrl u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .anyReq     (anyReq),
    .padSync    (padSync),
    .driveDone  (driveDone),
    .releaseDone(releaseDone),
    .strobe     (strobe),
    .padDriveLow(padDriveLow),
    .coreRst    (coreRst)
  );

  rseq_path #(
    .DRIVE_CYC  (DRIVE_CYC),
    .RELEASE_CYC(RELEASE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk        (clk),
    .porN       (porN),
    .strobe     (strobe),
    .copReq     (copReq),
    .clkMonReq  (clkMonReq),
    .padIn      (padIn),
    .padSync    (padSync),
    .driveDone  (driveDone),
    .releaseDone(releaseDone),
    .copPend    (copPend),
    .clkMonPend (clkMonPend),
    .vecSel     (vecSel)
  );

endmodule

// File: rtl/rseq_checker.sv
module rseq_checker (
  input logic       clk,
  input logic       porN,
  input logic       anyReq,
  input logic       padSync,
  input logic       copPend,
  input logic       clkMonPend,
  input logic       padDriveLow,
  input logic       coreRst,
  input logic [1:0] vecSel
);

  // R2
  drive_in_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    padDriveLow |-> coreRst);

  // R4
  deassert_pad_high_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreRst) |-> padSync);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!porN)
    (anyReq && coreRst) |=> padDriveLow);

  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    !coreRst |-> (!copPend && !clkMonPend));

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!coreRst && !$past(coreRst)) |-> $stable(vecSel));

  // R5
  vec_code_chk: assert property (@(posedge clk) disable iff (!porN)
    vecSel != 2'b11);

endmodule

bind reset_sequencer rseq_checker u_rseq_checker (
  .clk        (clk),
  .porN       (porN),
  .anyReq     (anyReq),
  .padSync    (padSync),
  .copPend    (copPend),
  .clkMonPend (clkMonPend),
  .padDriveLow(padDriveLow),
  .coreRst    (coreRst),
  .vecSel     (vecSel)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

  localparam int RST_LEN = 195;
  localparam int DRV_LEN = 131;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic lowVoltReq = 1'b0, illegalAddrReq = 1'b0, copReq = 1'b0, clkMonReq = 1'b0;
  logic extLow = 1'b0;
  logic padIn, padDriveLow, coreRst;
  logic [1:0] vecSel;
  int testsRun = 0, testsFailed = 0;
  int rstLen, drvLen;

  assign padIn = !(padDriveLow || extLow);

  always #4 clk = ~clk;

  reset_sequencer u_reset_sequencer (
    .clk(clk), .porN(porN), .lowVoltReq(lowVoltReq), .illegalAddrReq(illegalAddrReq),
    .copReq(copReq), .clkMonReq(clkMonReq), .padIn(padIn),
    .padDriveLow(padDriveLow), .coreRst(coreRst), .vecSel(vecSel)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts samples with reset high, starting at the current negedge
  task automatic measure();
    rstLen = 0;
    drvLen = 0;
    while (coreRst && rstLen < 2000) begin
      rstLen++;
      if (padDriveLow) drvLen++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: lowVoltReq = 1'b1;
      1: copReq = 1'b1;
      2: begin copReq = 1'b1; clkMonReq = 1'b1; end
      default: illegalAddrReq = 1'b1;
    endcase
    @(negedge clk);
    lowVoltReq = 1'b0; copReq = 1'b0; clkMonReq = 1'b0; illegalAddrReq = 1'b0;
  endtask

  task automatic testPowerOn();
    repeat (3) @(negedge clk);
    check("R2 reset pad drive", int'(padDriveLow), 1);
    check("R1 reset core", int'(coreRst), 1);
    porN = 1'b1;
    measure();
    check("R1 power-on length", rstLen, RST_LEN);
    check("R2 power-on drive", drvLen, DRV_LEN);
    check("R7 power-on vector", int'(vecSel), 0);
  endtask

  task automatic testCop();
    pulse(1);
    measure();
    check("R1 cop length", rstLen, RST_LEN);
    check("R2 cop drive", drvLen, DRV_LEN);
    check("R7 cop vector", int'(vecSel), 2);
    repeat (40) @(negedge clk);
    check("R10 vector held", int'(vecSel), 2);
    check("R10 still idle", int'(coreRst), 0);
  endtask

  task automatic testFlagsCleared();
    pulse(0);
    measure();
    check("R8 flags cleared lvd vector", int'(vecSel), 0);
  endtask

  task automatic testClkMonPriority();
    pulse(2);
    measure();
    check("R6 clkmon over cop", int'(vecSel), 1);
    pulse(3);
    measure();
    check("R7 illegal addr vector", int'(vecSel), 0);
  endtask

  task automatic testRestart();
    pulse(1);
    repeat (99) @(negedge clk);
    lowVoltReq = 1'b1;
    @(negedge clk);
    lowVoltReq = 1'b0;
    measure();
    check("R9 restart length", rstLen + 100, RST_LEN + 100);
    check("R9 restart drive", drvLen, DRV_LEN);
    check("R7 restart cop vector", int'(vecSel), 2);
  endtask

  task automatic testExtShort();
    pulse(2);
    measure();
    @(negedge clk);
    extLow = 1'b1;
    @(negedge clk);
    check("R3 sync edge1", int'(coreRst), 0);
    @(negedge clk);
    check("R3 sync edge2", int'(coreRst), 0);
    @(negedge clk);
    check("R3 sync edge3", int'(coreRst), 1);
    repeat (4) @(negedge clk);
    extLow = 1'b0;
    measure();
    check("R5 short external vector", int'(vecSel), 0);
  endtask

  task automatic testExtLong();
    @(negedge clk);
    extLow = 1'b1;
    repeat (20) @(negedge clk);
    copReq = 1'b1;
    @(negedge clk);
    copReq = 1'b0;
    repeat (380) @(negedge clk);
    check("R4 held by pad", int'(coreRst), 1);
    check("R4 pad released by block", int'(padDriveLow), 0);
    extLow = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4 still held edge2", int'(coreRst), 1);
    @(negedge clk);
    check("R4 falls edge3", int'(coreRst), 0);
    check("R5 low pad beats cop", int'(vecSel), 0);
  endtask

  initial begin
    testPowerOn();
    testCop();
    testFlagsCleared();
    testClkMonPriority();
    testRestart();
    testExtShort();
    testExtLong();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule